// File: doc/BRIEF.md
# Coalescing Line Write Buffer with Load Replay

This block sits between a write-through first-level data cache and the next cache level. Every store goes into the buffer. A store whose line is already held merges its enabled bytes into that entry. A store to any other line takes a free entry. Each entry leaves downstream as one full-line write over a valid/ready handshake, in the order the entries were allocated. The cache hands over its current copy of the line together with the allocating store. While the line is held, bytes that no store has written are filled in from that copy, one 256-bit half at a time.

For a short time after allocation, each half of the line is still being merged. A load probe whose line matches an entry in that state is refused with `ld_replay`. The match uses the line address only. The lower half (address bit 5 clear) stays blocked for `LO_WIN` cycles. The upper half (bit 5 set) stays blocked for `LO_WIN+1` cycles.

Each entry runs a small state machine:
- `E_FREE` goes to `E_BOTH` on allocation.
- `E_BOTH` goes to `E_UPPER` when the age reaches `LO_WIN`. This is the lower-half merge.
- `E_UPPER` goes to `E_DONE` when the age reaches `LO_WIN+1`. This is the upper-half merge.
- `E_DONE` goes to `E_FREE` when the entry is accepted downstream.

Top module: `wb_coalesce`

## Requirements
- R1: After reset, `st_ready` is 1, `dn_valid` is 0 and `ld_replay` is 0.
- R2: Stores to a line that is already held merge into the same entry. Where stores overlap, the later byte wins, and the line leaves as exactly one downstream write.
- R3: In the downstream data, every byte that no store enabled comes from the `st_fill` captured with the allocating store. The `st_fill` of a coalescing store has no effect.
- R4: Call the cycle after the edge that accepts an allocating store cycle 1. A load to that line with address bit 5 = 0 gives `ld_replay` = 1 in cycles 1 to `LO_WIN`, and 0 from cycle `LO_WIN+1` on.
- R5: A load to that line with address bit 5 = 1 gives `ld_replay` = 1 in cycles 1 to `LO_WIN+1`, and 0 from cycle `LO_WIN+2` on.
- R6: Conflict depends on the line address (bits above 5) only. Any byte offset in the line replays under R4/R5.
- R7: `ld_replay` is 0 when `ld_valid` is 0, when the line is not held, and when the window for that half has closed.
- R8: Entries drain oldest allocation first. `dn_valid` for an entry rises no earlier than cycle `LO_WIN+2` after its allocating store. `dn_addr` is the line address with bits 5:0 zero.
- R9: When all `NUM_ENT` entries are occupied, a store to a new line sees `st_ready` = 0 until an entry drains. A store that hits a held entry is still accepted, and no store is lost.
- R10: While `dn_valid` = 1 and `dn_ready` = 0, `dn_valid`, `dn_addr` and `dn_data` hold their values.
- R11: A store whose line matches the entry being offered downstream sees `st_ready` = 0 until that write is accepted. It then allocates a fresh entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request |
| st_ready | output | 1 | Store accepted on this edge when high with `st_valid` |
| st_line | input | ADDR_W-6 | Store line address |
| st_be | input | LINE_BYTES | Byte enables for the line |
| st_data | input | LINE_BYTES*8 | Store bytes, line aligned |
| st_fill | input | LINE_BYTES*8 | Cache copy of the line, used on allocation |
| ld_valid | input | 1 | Load probe valid |
| ld_addr | input | ADDR_W | Load byte address |
| ld_replay | output | 1 | Load must be replayed |
| dn_valid | output | 1 | Line write offered downstream |
| dn_ready | input | 1 | Downstream accepts |
| dn_addr | output | ADDR_W | Line-aligned address of the write |
| dn_data | output | LINE_BYTES*8 | Merged line |

## Verification
The bench builds the block with `NUM_ENT` = 4 and `LO_WIN` = 6, so the upper window is 7 cycles. With these values both window edges, plus two cycles beyond them, fit into one short probe loop. Four stores are enough to fill the buffer, so the back-pressure stall and its release through a drain come within a few dozen cycles. The head-clash stall is exercised in the same run.

// File: rtl/wb_pkg.sv
package wb_pkg;
    typedef enum logic [1:0] {
        E_FREE  = 2'd0,
        E_BOTH  = 2'd1,
        E_UPPER = 2'd2,
        E_DONE  = 2'd3
    } ent_state_t;
endpackage

// File: rtl/wb_entry.sv
module wb_entry
    import wb_pkg::*;
#(
    parameter int LINE_BYTES = 64,
    parameter int TAG_W      = 26,
    parameter int LO_WIN     = 33
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    alloc,
    input  logic                    wr,
    input  logic                    drain,
    input  logic [TAG_W-1:0]        in_tag,
    input  logic [LINE_BYTES-1:0]   in_be,
    input  logic [LINE_BYTES*8-1:0] in_data,
    input  logic [LINE_BYTES*8-1:0] in_fill,
    output logic                    busy,
    output logic                    lo_open,
    output logic                    hi_open,
    output logic                    done,
    output logic [TAG_W-1:0]        tag,
    output logic [LINE_BYTES*8-1:0] data
);
    localparam int HI_WIN = LO_WIN + 1;
    localparam int HALF   = LINE_BYTES / 2;
    localparam int AGE_W  = $clog2(HI_WIN + 2);
    localparam int DATA_W = LINE_BYTES * 8;

    ent_state_t             state_q, state_d;
    logic [AGE_W-1:0]       age_q;
    logic [LINE_BYTES-1:0]  mask_q;
    logic [DATA_W-1:0]      data_q, fill_q;
    logic [TAG_W-1:0]       tag_q;
    logic                   lo_merge, hi_merge;

    assign lo_merge = (state_q == E_BOTH)  && (age_q == AGE_W'(LO_WIN));
    assign hi_merge = (state_q == E_UPPER) && (age_q == AGE_W'(HI_WIN));

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= E_FREE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            E_FREE:  if (alloc)    state_d = E_BOTH;
            E_BOTH:  if (lo_merge) state_d = E_UPPER;
            E_UPPER: if (hi_merge) state_d = E_DONE;
            E_DONE:  if (drain)    state_d = E_FREE;
        endcase
    end

    always_comb begin
        busy    = (state_q != E_FREE);
        lo_open = (state_q == E_BOTH);
        hi_open = (state_q == E_BOTH) || (state_q == E_UPPER);
        done    = (state_q == E_DONE);
        tag     = tag_q;
        data    = data_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)               age_q <= '0;
        else if (alloc)           age_q <= AGE_W'(1);
        else if (hi_open)         age_q <= age_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (alloc) begin
            tag_q  <= in_tag;
            fill_q <= in_fill;
            mask_q <= in_be;
            for (int b = 0; b < LINE_BYTES; b++)
                data_q[b*8 +: 8] <= in_be[b] ? in_data[b*8 +: 8] : 8'h00;
        end else begin
            for (int b = 0; b < LINE_BYTES; b++) begin
                if (wr && in_be[b]) begin
                    data_q[b*8 +: 8] <= in_data[b*8 +: 8];
                    mask_q[b]        <= 1'b1;
                end else if (((b < HALF) ? lo_merge : hi_merge) && !mask_q[b]) begin
                    data_q[b*8 +: 8] <= fill_q[b*8 +: 8];
                    mask_q[b]        <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/wb_coalesce.sv
module wb_coalesce #(
    parameter int NUM_ENT    = 6,
    parameter int LINE_BYTES = 64,
    parameter int ADDR_W     = 32,
    parameter int LO_WIN     = 33
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   st_valid,
    output logic                                   st_ready,
    input  logic [ADDR_W-$clog2(LINE_BYTES)-1:0]   st_line,
    input  logic [LINE_BYTES-1:0]                  st_be,
    input  logic [LINE_BYTES*8-1:0]                st_data,
    input  logic [LINE_BYTES*8-1:0]                st_fill,
    input  logic                                   ld_valid,
    input  logic [ADDR_W-1:0]                      ld_addr,
    output logic                                   ld_replay,
    output logic                                   dn_valid,
    input  logic                                   dn_ready,
    output logic [ADDR_W-1:0]                      dn_addr,
    output logic [LINE_BYTES*8-1:0]                dn_data
);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int TAG_W  = ADDR_W - OFF_W;
    localparam int DATA_W = LINE_BYTES * 8;
    localparam int PTR_W  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;
    localparam int CNT_W  = $clog2(NUM_ENT + 1);

    logic [NUM_ENT-1:0] busy, lo_open, hi_open, done;
    logic [NUM_ENT-1:0] alloc, wr, drain, st_match, ld_conf;
    logic [TAG_W-1:0]   tag  [NUM_ENT];
    logic [DATA_W-1:0]  data [NUM_ENT];
    logic [PTR_W-1:0]   head, tail;
    logic [CNT_W-1:0]   count;
    logic               st_hit, st_fire, dn_fire, head_clash, full, ld_upper;
    logic [TAG_W-1:0]   ld_tag;
    logic               ld_off_unused;

    assign ld_tag        = ld_addr[ADDR_W-1:OFF_W];
    assign ld_upper      = ld_addr[OFF_W-1];
    assign ld_off_unused = ^ld_addr[OFF_W-2:0];

    for (genvar gi = 0; gi < NUM_ENT; gi++) begin : g_ent
        wb_entry #(
            .LINE_BYTES(LINE_BYTES),
            .TAG_W     (TAG_W),
            .LO_WIN    (LO_WIN)
        ) u_ent (
            .clk    (clk),
            .rst_n  (rst_n),
            .alloc  (alloc[gi]),
            .wr     (wr[gi]),
            .drain  (drain[gi]),
            .in_tag (st_line),
            .in_be  (st_be),
            .in_data(st_data),
            .in_fill(st_fill),
            .busy   (busy[gi]),
            .lo_open(lo_open[gi]),
            .hi_open(hi_open[gi]),
            .done   (done[gi]),
            .tag    (tag[gi]),
            .data   (data[gi])
        );
        assign st_match[gi] = busy[gi] && (tag[gi] == st_line);
        assign ld_conf[gi]  = busy[gi] && (tag[gi] == ld_tag) &&
                              (ld_upper ? hi_open[gi] : lo_open[gi]);
        assign alloc[gi]    = st_fire && !st_hit && (tail == PTR_W'(gi));
        assign wr[gi]       = st_fire && st_match[gi];
        assign drain[gi]    = dn_fire && (head == PTR_W'(gi));
    end

    assign st_hit     = |st_match;
    assign full       = (count == CNT_W'(NUM_ENT));
    assign dn_valid   = done[head];
    assign dn_fire    = dn_valid && dn_ready;
    assign head_clash = dn_valid && st_match[head];
    assign st_ready   = !head_clash && (st_hit || !full);
    assign st_fire    = st_valid && st_ready;
    assign ld_replay  = ld_valid && (|ld_conf);
    assign dn_addr    = {tag[head], {OFF_W{1'b0}}};
    assign dn_data    = data[head];

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(NUM_ENT - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (st_fire && !st_hit) tail <= ptr_next(tail);
            if (dn_fire)            head <= ptr_next(head);
            unique case ({st_fire && !st_hit, dn_fire})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/wb_coalesce_chk.sv
module wb_coalesce_chk #(
    parameter int NUM_ENT = 6,
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 512,
    parameter int CNT_W   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               st_valid,
    input logic               st_ready,
    input logic               ld_valid,
    input logic               ld_replay,
    input logic               dn_valid,
    input logic               dn_ready,
    input logic [ADDR_W-1:0]  dn_addr,
    input logic [DATA_W-1:0]  dn_data,
    input logic [CNT_W-1:0]   occ,
    input logic [NUM_ENT-1:0] st_match
);
    AST_DN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid && !dn_ready |=> dn_valid && $stable(dn_addr) && $stable(dn_data)); // R10

    AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid && (occ == CNT_W'(NUM_ENT)) && !(|st_match) |-> !st_ready); // R9

    AST_ONE_HOLDER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(st_match)); // R2

    AST_REPLAY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_valid |-> !ld_replay); // R7

    AST_DRAIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid && dn_ready && !(st_valid && st_ready && !(|st_match))
        |=> (occ + 1'b1) == $past(occ)); // R8
endmodule

bind wb_coalesce wb_coalesce_chk #(
    .NUM_ENT(NUM_ENT),
    .ADDR_W (ADDR_W),
    .DATA_W (LINE_BYTES * 8),
    .CNT_W  ($clog2(NUM_ENT + 1))
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .st_valid (st_valid),
    .st_ready (st_ready),
    .ld_valid (ld_valid),
    .ld_replay(ld_replay),
    .dn_valid (dn_valid),
    .dn_ready (dn_ready),
    .dn_addr  (dn_addr),
    .dn_data  (dn_data),
    .occ      (count),
    .st_match (st_match)
);

// File: tb/sim_wb_coalesce.sv
module sim_wb_coalesce;
    localparam int NE = 4;
    localparam int LB = 64;
    localparam int AW = 32;
    localparam int LW = 6;
    localparam int HW = LW + 1;
    localparam int DW = LB * 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic st_valid = 1'b0, st_ready;
    logic [AW-7:0] st_line = '0;
    logic [LB-1:0] st_be = '0;
    logic [DW-1:0] st_data = '0, st_fill = '0;
    logic ld_valid = 1'b0, ld_replay;
    logic [AW-1:0] ld_addr = '0;
    logic dn_valid, dn_ready = 1'b0;
    logic [AW-1:0] dn_addr;
    logic [DW-1:0] dn_data;

    int errs = 0, checks = 0, dn_seen = 0;
    logic [AW-1:0] q_addr[$];
    logic [DW-1:0] q_data[$];

    always #10 clk = ~clk;

    wb_coalesce #(.NUM_ENT(NE), .LINE_BYTES(LB), .ADDR_W(AW), .LO_WIN(LW)) u0 (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
        .st_line(st_line), .st_be(st_be), .st_data(st_data), .st_fill(st_fill),
        .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_replay(ld_replay),
        .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_addr(dn_addr), .dn_data(dn_data));

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] overlay(input logic [DW-1:0] base,
                                              input logic [LB-1:0] be,
                                              input logic [DW-1:0] d);
        logic [DW-1:0] r = base;
        for (int b = 0; b < LB; b++) if (be[b]) r[b*8 +: 8] = d[b*8 +: 8];
        return r;
    endfunction

    task automatic expect_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        q_addr.push_back(a);
        q_data.push_back(d);
    endtask

    // Drive one store; returns 1 ns after the accepting edge.
    task automatic do_store(input logic [AW-1:0] a, input logic [LB-1:0] be,
                            input logic [DW-1:0] d, input logic [DW-1:0] f);
        @(negedge clk);
        st_valid = 1'b1; st_line = a[AW-1:6]; st_be = be; st_data = d; st_fill = f;
        forever begin
            #1;
            if (st_ready) break;
            @(negedge clk);
        end
        @(posedge clk);
        #1 st_valid = 1'b0;
    endtask

    // Scoreboard monitor: samples just before each rising edge.
    initial forever begin
        @(negedge clk);
        #8;
        if (dn_valid && dn_ready) begin
            dn_seen++;
            if (q_addr.size() == 0) begin
                checks++; errs++;
                $display("FAIL R8 unexpected write actual=%0h expected=none", dn_addr);
            end else begin
                chk("R8 drain order", DW'(dn_addr), DW'(q_addr.pop_front()));
                chk("R2/R3 merged line", dn_data, q_data.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic [DW-1:0] fa, fb, da, db, ex, fy, dy, ey;
        logic [DW-1:0] ef[NE];
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        ld_valid = 1'b1; ld_addr = 32'h0000_1000;
        #1;
        chk("R1 st_ready", DW'(st_ready), DW'(1));
        chk("R1 dn_valid", DW'(dn_valid), DW'(0));
        chk("R1/R7 ld_replay", DW'(ld_replay), DW'(0));
        ld_valid = 1'b0;

        // Coalescing two overlapping stores into line 0x1000 (R2, R3, R8)
        fa = {16{32'hA5A5_0F0F}}; fb = {16{32'h1234_5678}};
        da = {16{32'h1111_1111}}; db = {16{32'h2222_2222}};
        do_store(32'h1000, 64'h0000_0000_0000_000F, da, fa);
        do_store(32'h1000, 64'h0000_0100_0000_003C, db, fb);
        ex = overlay(overlay(fa, 64'hF, da), 64'h0000_0100_0000_003C, db);
        for (int d = 2; d <= HW + 1; d++) begin
            @(negedge clk); #1;
            chk("R8 dn_valid timing", DW'(dn_valid), DW'(d == HW + 1));
        end

        // Replay windows on line 0x2000 (R4, R5, R6, R7)
        fy = {16{32'h5A5A_C3C3}}; dy = {16{32'h7777_7777}};
        ey = overlay(fy, 64'h1, dy);
        do_store(32'h2000, 64'h1, dy, fy);
        for (int d = 1; d <= HW + 2; d++) begin
            @(negedge clk);
            ld_valid = 1'b1;
            ld_addr = 32'h2007; #1;
            chk("R4 lower window", DW'(ld_replay), DW'(d <= LW));
            ld_addr = 32'h201F; #1;
            chk("R6 lower offset 31", DW'(ld_replay), DW'(d <= LW));
            ld_addr = 32'h2020; #1;
            chk("R5 upper offset 32", DW'(ld_replay), DW'(d <= HW));
            ld_addr = 32'h203F; #1;
            chk("R5/R6 upper offset 63", DW'(ld_replay), DW'(d <= HW));
            ld_addr = 32'h3007; #1;
            chk("R7 line not held", DW'(ld_replay), DW'(0));
            ld_valid = 1'b0; #1;
            chk("R7 no probe", DW'(ld_replay), DW'(0));
        end
        expect_wr(32'h1000, ex);
        expect_wr(32'h2000, ey);
        @(negedge clk); dn_ready = 1'b1;
        repeat (6) @(negedge clk);
        chk("R2 one write per line", DW'(dn_seen), DW'(2));
        chk("R8 queue drained", DW'(q_addr.size()), DW'(0));
        dn_ready = 1'b0;

        // Full buffer back-pressure (R9, R10)
        for (int i = 0; i < NE; i++) begin
            ef[i] = {16{32'h0BAD_0000 + i}};
            do_store(32'h4000 + 64 * i, 64'h3 << (2 * i), {16{32'hC0DE_0000 + i}}, ef[i]);
            ef[i] = overlay(ef[i], 64'h3 << (2 * i), {16{32'hC0DE_0000 + i}});
        end
        @(negedge clk);
        st_valid = 1'b1; st_line = 26'(32'h4048 >> 6); st_be = 64'h100;
        st_data = {16{32'hEEEE_EEEE}}; st_fill = '1;
        #1 chk("R9 hit accepted while full", DW'(st_ready), DW'(1));
        @(posedge clk); #1 st_valid = 1'b0;
        ef[1] = overlay(ef[1], 64'h100, {16{32'hEEEE_EEEE}});
        @(negedge clk);
        st_valid = 1'b1; st_line = 26'(32'h5000 >> 6); st_be = 64'hFF00;
        st_data = {16{32'h9999_9999}}; st_fill = {16{32'h4444_4444}};
        for (int k = 0; k < HW + 3; k++) begin
            #1 chk("R9 miss stalled while full", DW'(st_ready), DW'(0));
            if (k >= HW + 1) begin
                chk("R10 head held", DW'(dn_valid), DW'(1));
                chk("R10 head addr held", DW'(dn_addr), DW'(32'h4000));
            end
            @(negedge clk);
        end
        for (int i = 0; i < NE; i++) expect_wr(32'h4000 + 64 * i, ef[i]);
        expect_wr(32'h5000, overlay({16{32'h4444_4444}}, 64'hFF00, {16{32'h9999_9999}}));
        dn_ready = 1'b1;
        forever begin
            #1;
            if (st_ready) break;
            @(negedge clk);
        end
        @(posedge clk); #1 st_valid = 1'b0;
        repeat (HW + 8) @(negedge clk);
        chk("R9 no store lost", DW'(q_addr.size()), DW'(0));
        dn_ready = 1'b0;

        // Store to line being offered downstream (R11)
        do_store(32'h6000, 64'h1, {16{32'h3131_3131}}, {16{32'h6060_6060}});
        repeat (HW + 2) @(negedge clk);
        st_valid = 1'b1; st_line = 26'(32'h6000 >> 6); st_be = 64'h2;
        st_data = {16{32'h3232_3232}}; st_fill = {16{32'h6161_6161}};
        for (int k = 0; k < 2; k++) begin
            #1 chk("R11 head clash stalls", DW'(st_ready), DW'(0));
            @(negedge clk);
        end
        expect_wr(32'h6000, overlay({16{32'h6060_6060}}, 64'h1, {16{32'h3131_3131}}));
        expect_wr(32'h6000, overlay({16{32'h6161_6161}}, 64'h2, {16{32'h3232_3232}}));
        dn_ready = 1'b1;
        forever begin
            #1;
            if (st_ready) break;
            @(negedge clk);
        end
        @(posedge clk); #1 st_valid = 1'b0;
        repeat (HW + 6) @(negedge clk);
        chk("R11 two separate writes", DW'(q_addr.size()), DW'(0));

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule